// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block sits in front of a 2 KB byte-wide program flash array. The array is eight sectors of 256 bytes, and each sector is split into 16-byte pages. Software-side logic issues one command per cycle on a small command port. The controller erases a single byte, a page, a sector or the whole array. It programs a page through a 16-byte staging buffer that may be only partly filled. It refuses normal reads from sectors marked secure, and it checks array contents by computing a 32-bit CRC over one sector or over the whole array. No direct verify path is provided.

Every program and erase occupies a fixed window of `OP_CYCLES` clock cycles, counted inside the controller. During that window the controller walks the addressed range one byte per cycle over a plain synchronous-write, combinational-read array port. The array itself, and its cell physics, are outside the block. An erased byte reads 0xFF. Programming can only clear bits: the byte becomes old AND new.

Top module: `flash_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `err` are 0, `crc_out` is 0xFFFFFFFF and the page buffer holds no valid byte.
- R2: An accepted erase command sets bytes to 0xFF and leaves every other byte unchanged. The opcode picks the range: 2 erases the byte at `cmd_addr`, 3 erases the page `cmd_addr[10:4]`, 4 erases the sector `cmd_addr[10:8]`, and 5 erases all 2048 bytes.
- R3: Opcode 0 (load) stores `cmd_data` at offset `cmd_addr[3:0]` of the page buffer, marks that offset valid, and makes `cmd_addr[10:4]` the target page; the most recent load sets the page. Opcode 1 (program) writes old AND buffered data into each valid offset of the target page and leaves invalid offsets untouched.
- R4: The valid mask is cleared when a program operation completes and when opcode 7 (buffer clear) is accepted, so a later program writes only bytes loaded after that point.
- R5: Program and erase commands hold `busy` high for exactly `OP_CYCLES` cycles after the accepting clock edge. `done` is high for the single cycle after `busy` falls.
- R6: Any command presented while `busy` is high is ignored, and `err` is set on the next edge. `err` returns to 0 on the next accepted command.
- R7: `rd_ok` is 1 and `rd_data` equals the array byte at `rd_addr` only when the controller is idle and the sector `rd_addr[10:8]` does not have its `sec_mask` bit set. Otherwise `rd_ok` and `rd_data` are 0.
- R8: Opcode 6 computes a CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF, MSB-first, no reflection and no final XOR. It processes one byte per cycle in ascending address order. It covers the whole array when `cmd_data[0]`=1 and the sector `cmd_addr[10:8]` otherwise, and secured sectors are included. `busy` stays high for as many cycles as there are bytes, and `crc_out` holds the result once `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Opcode (see R2, R3, R4, R8) |
| cmd_addr | input | ADDR_W | Byte address used by the command |
| cmd_data | input | 8 | Load byte, or CRC scope select in bit 0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command was rejected while busy |
| crc_out | output | 32 | Last CRC result |
| sec_mask | input | SECTORS | Per-sector read security, 1 = secured |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, 0 when refused |
| rd_ok | output | 1 | Read accepted |
| arr_addr | output | ADDR_W | Array address |
| arr_we | output | 1 | Array write enable |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data, combinational from arr_addr |

## Verification
A corrupted valid mask or target page appears as wrong bytes in the page that was programmed or in its neighbour. A readback of that range right after `done` shows it. A wrong window counter shows up directly as a `busy` length that differs from `OP_CYCLES`, or as a missing or doubled `done` pulse on the first command. A fault in the CRC shift register or the address walk changes `crc_out` as soon as the first sector CRC completes. A fault in the security or busy gating shows on `rd_ok` and `rd_data` in the same cycle as the read.

// File: rtl/flash_ctrl_pkg.sv
// Shared types and the CRC step for the flash controller.
// Assumes byte-wide data and an MSB-first CRC-32 without reflection.
package flash_ctrl_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_PROG  = 3'd1,
        OP_ERB   = 3'd2,
        OP_ERP   = 3'd3,
        OP_ERS   = 3'd4,
        OP_ERC   = 3'd5,
        OP_CRC   = 3'd6,
        OP_BCLR  = 3'd7
    } flash_op_e;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ERASE = 2'd1,
        WK_PROG  = 2'd2,
        WK_CRC   = 2'd3
    } walk_e;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

    // Fold one byte into the running CRC, most significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[31] ^ b[i];
            r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/flash_page_buf.sv
// Page staging buffer: one data byte and one valid bit per page offset,
// plus the target page number taken from the most recent load.
// Assumes load and clear never occur in the same cycle.
module flash_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int PAGE_AW    = $clog2(PAGE_BYTES),
    parameter int PAGE_NW    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PAGE_AW-1:0] load_off,
    input  logic [PAGE_NW-1:0] load_page,
    input  logic [7:0]         load_data,
    input  logic               clear,
    input  logic [PAGE_AW-1:0] rd_off,
    output logic [PAGE_NW-1:0] page,
    output logic [7:0]         rd_data,
    output logic               rd_valid
);

    logic [PAGE_BYTES-1:0] valid_vec;
    logic [7:0]            data_arr [PAGE_BYTES];
    logic [PAGE_NW-1:0]    page_q;

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
        logic       v_q;
        logic [7:0] d_q;
        logic       hit;
        assign hit = load && (load_off == PAGE_AW'(i));

        // Track whether this offset holds a byte to program.
        always_ff @(posedge clk) begin
            if (!rst_n)      v_q <= 1'b0;
            else if (clear)  v_q <= 1'b0;
            else if (hit)    v_q <= 1'b1;
        end

        // Capture the byte written to this offset.
        always_ff @(posedge clk) begin
            if (hit) d_q <= load_data;
        end

        assign valid_vec[i] = v_q;
        assign data_arr[i]  = d_q;
    end

    // Remember the page named by the latest load.
    always_ff @(posedge clk) begin
        if (!rst_n)    page_q <= '0;
        else if (load) page_q <= load_page;
    end

    assign page     = page_q;
    assign rd_data  = data_arr[rd_off];
    assign rd_valid = valid_vec[rd_off];

    // R3
    load_marks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> valid_vec[$past(load_off)]);

    // R4
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !rd_valid);

endmodule

// File: rtl/flash_seq.sv
// Operation sequencer: holds the active walk kind, base and length and
// counts one cycle per step. Erase and program end after a fixed window.
// A CRC walk ends after its last byte. Assumes the window covers the
// longest range, and that start only arrives while idle.
module flash_seq
    import flash_ctrl_pkg::*;
#(
    parameter int OP_CYCLES = 2080,
    parameter int ADDR_W    = 11,
    parameter int CNT_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  walk_e             kind_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W:0]   len_i,
    output logic              busy,
    output logic              done,
    output logic              finish,
    output walk_e             kind,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  cnt,
    output logic              in_range
);

    logic              busy_q, done_q;
    walk_e             kind_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W:0]   len_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              end_hit;

    // Detect the last cycle of the current walk.
    always_comb begin
        if (kind_q == WK_CRC) end_hit = (cnt_q == CNT_W'(len_q) - CNT_W'(1));
        else                  end_hit = (cnt_q == CNT_W'(OP_CYCLES - 1));
    end

    assign finish = busy_q && end_hit;

    // Launch, step and retire a walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            kind_q <= WK_IDLE;
            base_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                kind_q <= kind_i;
                base_q <= base_i;
                len_q  <= len_i;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (end_hit) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    kind_q <= WK_IDLE;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign kind     = kind_q;
    assign base     = base_q;
    assign cnt      = cnt_q;
    assign in_range = busy_q && (cnt_q < CNT_W'(len_q));

    // R5
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && kind_q != WK_CRC) |-> (cnt_q < CNT_W'(OP_CYCLES)));

    // R5
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));

endmodule

// File: rtl/flash_crc32.sv
// CRC accumulator: restarts on start, folds one byte per step and
// latches the final value on the last step. Assumes step is high on the
// finish cycle.
module flash_crc32
    import flash_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        step,
    input  logic        finish,
    input  logic [7:0]  byte_in,
    output logic [31:0] result
);

    logic [31:0] run_q, res_q, next_c;

    assign next_c = crc32_step(run_q, byte_in);

    // Maintain the running CRC during a walk.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_q <= CRC_INIT;
        else if (start) run_q <= CRC_INIT;
        else if (step)  run_q <= next_c;
    end

    // Hold the completed CRC for readout.
    always_ff @(posedge clk) begin
        if (!rst_n)                res_q <= CRC_INIT;
        else if (step && finish)   res_q <= next_c;
    end

    assign result = res_q;

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && finish) |=> $stable(res_q));

endmodule

// File: rtl/flash_ctrl.sv
// Flash program/erase front end. Decodes commands, launches walks over
// the array port, stages page data, gates secure reads and runs the CRC.
// Assumes a combinational-read, synchronous-write array, sizes that are
// powers of two, and OP_CYCLES no smaller than the array size.
module flash_ctrl
    import flash_ctrl_pkg::*;
#(
    parameter int SECTORS      = 8,
    parameter int SECTOR_BYTES = 256,
    parameter int PAGE_BYTES   = 16,
    parameter int OP_CYCLES    = 2080,
    parameter int ADDR_W       = $clog2(SECTORS * SECTOR_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [7:0]         cmd_data,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [31:0]        crc_out,
    input  logic [SECTORS-1:0] sec_mask,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [7:0]         rd_data,
    output logic               rd_ok,
    output logic [ADDR_W-1:0]  arr_addr,
    output logic               arr_we,
    output logic [7:0]         arr_wdata,
    input  logic [7:0]         arr_rdata
);

    localparam int TOTAL    = SECTORS * SECTOR_BYTES;
    localparam int PAGE_AW  = $clog2(PAGE_BYTES);
    localparam int SECT_AW  = $clog2(SECTOR_BYTES);
    localparam int PAGE_NW  = ADDR_W - PAGE_AW;
    localparam int MAX_SPAN = (OP_CYCLES > TOTAL) ? OP_CYCLES : TOTAL;
    localparam int CNT_W    = $clog2(MAX_SPAN + 1);

    logic              accept, start, load, bclr;
    walk_e             kind_d, kind_q;
    logic [ADDR_W-1:0] base_d, base_q;
    logic [ADDR_W:0]   len_d;
    logic [CNT_W-1:0]  cnt;
    logic              in_range, finish, busy_w, err_q;
    logic [PAGE_NW-1:0] buf_page;
    logic [7:0]        buf_byte;
    logic              buf_valid, buf_clear;
    logic              rd_secure;
    flash_op_e         op;

    assign op     = flash_op_e'(cmd_op);
    assign accept = cmd_valid && !busy_w;
    assign load   = accept && (op == OP_LOAD);
    assign bclr   = accept && (op == OP_BCLR);

    // Decode the walk kind, start address and length of a command.
    always_comb begin
        kind_d = WK_IDLE;
        base_d = '0;
        len_d  = '0;
        unique case (op)
            OP_ERB: begin
                kind_d = WK_ERASE;
                base_d = cmd_addr;
                len_d  = (ADDR_W+1)'(1);
            end
            OP_ERP: begin
                kind_d = WK_ERASE;
                base_d = {cmd_addr[ADDR_W-1:PAGE_AW], {PAGE_AW{1'b0}}};
                len_d  = (ADDR_W+1)'(PAGE_BYTES);
            end
            OP_ERS: begin
                kind_d = WK_ERASE;
                base_d = {cmd_addr[ADDR_W-1:SECT_AW], {SECT_AW{1'b0}}};
                len_d  = (ADDR_W+1)'(SECTOR_BYTES);
            end
            OP_ERC: begin
                kind_d = WK_ERASE;
                len_d  = (ADDR_W+1)'(TOTAL);
            end
            OP_PROG: begin
                kind_d = WK_PROG;
                base_d = {buf_page, {PAGE_AW{1'b0}}};
                len_d  = (ADDR_W+1)'(PAGE_BYTES);
            end
            OP_CRC: begin
                kind_d = WK_CRC;
                if (cmd_data[0]) begin
                    len_d = (ADDR_W+1)'(TOTAL);
                end else begin
                    base_d = {cmd_addr[ADDR_W-1:SECT_AW], {SECT_AW{1'b0}}};
                    len_d  = (ADDR_W+1)'(SECTOR_BYTES);
                end
            end
            default: begin
                kind_d = WK_IDLE;
            end
        endcase
    end

    assign start = accept && (kind_d != WK_IDLE);

    // Flag a command that arrived while busy; clear on the next accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n)                  err_q <= 1'b0;
        else if (cmd_valid && busy_w) err_q <= 1'b1;
        else if (accept)             err_q <= 1'b0;
    end

    flash_seq #(
        .OP_CYCLES(OP_CYCLES),
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .kind_i  (kind_d),
        .base_i  (base_d),
        .len_i   (len_d),
        .busy    (busy_w),
        .done    (done),
        .finish  (finish),
        .kind    (kind_q),
        .base    (base_q),
        .cnt     (cnt),
        .in_range(in_range)
    );

    assign buf_clear = bclr || (finish && kind_q == WK_PROG);

    flash_page_buf #(
        .PAGE_BYTES(PAGE_BYTES),
        .PAGE_AW   (PAGE_AW),
        .PAGE_NW   (PAGE_NW)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_off (cmd_addr[PAGE_AW-1:0]),
        .load_page(cmd_addr[ADDR_W-1:PAGE_AW]),
        .load_data(cmd_data),
        .clear    (buf_clear),
        .rd_off   (cnt[PAGE_AW-1:0]),
        .page     (buf_page),
        .rd_data  (buf_byte),
        .rd_valid (buf_valid)
    );

    flash_crc32 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start && kind_d == WK_CRC),
        .step   (busy_w && kind_q == WK_CRC),
        .finish (finish),
        .byte_in(arr_rdata),
        .result (crc_out)
    );

    // Steer the array port between the walker and the read path.
    always_comb begin
        arr_addr  = busy_w ? (base_q + cnt[ADDR_W-1:0]) : rd_addr;
        arr_we    = in_range && ((kind_q == WK_ERASE) ||
                                 (kind_q == WK_PROG && buf_valid));
        arr_wdata = (kind_q == WK_ERASE) ? 8'hFF : (arr_rdata & buf_byte);
    end

    // Gate normal reads by idleness and sector security.
    always_comb begin
        rd_secure = sec_mask[rd_addr[ADDR_W-1:SECT_AW]];
        rd_ok     = !busy_w && !rd_secure;
        rd_data   = rd_ok ? arr_rdata : 8'h00;
    end

    assign busy = busy_w;
    assign err  = err_q;

    // R6
    busy_cmd_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> err);

    // R3
    only_clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && kind_q == WK_PROG) |-> ((arr_wdata & ~arr_rdata) == 8'h00));

    // R2
    write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R7
    secure_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_mask[rd_addr[ADDR_W-1:SECT_AW]] || busy) |-> (!rd_ok && rd_data == 8'h00));

endmodule

// File: tb/flash_ctrl_test.sv
`timescale 1ns/1ps
module flash_ctrl_test;

    localparam int SECTORS = 8;
    localparam int SB      = 256;
    localparam int PB      = 16;
    localparam int OPC     = 2080;
    localparam int TOTAL   = SECTORS * SB;
    localparam int AW      = 11;

    localparam logic [2:0] C_LOAD = 3'd0, C_PROG = 3'd1, C_ERB = 3'd2, C_ERP = 3'd3,
                           C_ERS = 3'd4, C_ERC = 3'd5, C_CRC = 3'd6, C_BCLR = 3'd7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic [2:0]         cmd_op = '0;
    logic [AW-1:0]      cmd_addr = '0;
    logic [7:0]         cmd_data = '0;
    logic               busy, done, err, rd_ok, arr_we;
    logic [31:0]        crc_out;
    logic [SECTORS-1:0] sec_mask = '0;
    logic [AW-1:0]      rd_addr = '0;
    logic [7:0]         rd_data, arr_wdata, arr_rdata;
    logic [AW-1:0]      arr_addr;

    flash_ctrl #(.SECTORS(SECTORS), .SECTOR_BYTES(SB), .PAGE_BYTES(PB), .OP_CYCLES(OPC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .done(done),
        .err(err), .crc_out(crc_out), .sec_mask(sec_mask), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_ok(rd_ok), .arr_addr(arr_addr), .arr_we(arr_we),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    // Behavioural array harness.
    logic [7:0] mem [TOTAL];
    logic [7:0] pre [TOTAL];
    logic       preload = 1'b0;
    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < TOTAL; i++) mem[i] <= pre[i];
        end else if (arr_we) begin
            mem[arr_addr] <= arr_wdata;
        end
    end
    assign arr_rdata = mem[arr_addr];

    // Bench reference state.
    logic [7:0] ref_mem [TOTAL];
    logic [7:0] bm_data [PB];
    logic       bm_valid [PB];
    int unsigned bm_page = 0;
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int base, input int len);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {ref_mem[base + i], 24'h0};
            for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
        end
        return c;
    endfunction

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input int exp_cyc, input string tag);
        int  c;
        bit  d1, d2;
        issue(op, a, d);
        wait_idle(c);
        d1 = done;
        @(negedge clk);
        d2 = done;
        chk(c == exp_cyc && d1 && !d2, tag, c, exp_cyc);
    endtask

    task automatic ref_erase(input int base, input int len);
        for (int i = 0; i < len; i++) ref_mem[base + i] = 8'hFF;
    endtask

    task automatic do_load(input int page, input int off, input logic [7:0] d);
        issue(C_LOAD, AW'(page * PB + off), d);
        bm_page = page;
        bm_data[off] = d;
        bm_valid[off] = 1'b1;
    endtask

    task automatic bm_clear();
        for (int i = 0; i < PB; i++) bm_valid[i] = 1'b0;
    endtask

    task automatic do_prog(input string tag);
        run(C_PROG, '0, 8'h00, OPC, tag);
        for (int i = 0; i < PB; i++)
            if (bm_valid[i]) ref_mem[bm_page * PB + i] = ref_mem[bm_page * PB + i] & bm_data[i];
        bm_clear();
    endtask

    task automatic cmp_range(input int base, input int len, input string tag);
        int mism = 0;
        logic [7:0] fa = 0, fe = 0;
        logic [7:0] e;
        bit sec;
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            rd_addr = AW'(base + i);
            #1;
            sec = sec_mask[(base + i) / SB];
            e = sec ? 8'h00 : ref_mem[base + i];
            if (rd_data !== e || rd_ok !== !sec) begin
                if (mism == 0) begin fa = rd_data; fe = e; end
                mism++;
            end
        end
        chk(mism == 0, tag, fa, fe);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned s;
        int c;
        s = $urandom(32'd20240611);
        bm_clear();
        for (int i = 0; i < TOTAL; i++) begin
            pre[i] = 8'($urandom);
            ref_mem[i] = pre[i];
        end
        preload = 1'b1;
        repeat (2) @(negedge clk);
        preload = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !done && !err, "R1 status after reset", {busy, done, err}, 0);
        chk(crc_out == 32'hFFFFFFFF, "R1 crc after reset", crc_out, 32'hFFFFFFFF);
        do_prog("R1 empty buffer program window");
        cmp_range(0, 16, "R1 program with empty buffer changes nothing");

        // R7 plain readback of preload
        cmp_range(0, 64, "R7 idle readback");

        // R3 partial program onto random contents
        do_load(5, 2, 8'h3C);
        do_load(5, 7, 8'hA5);
        do_load(5, 15, 8'h00);
        do_prog("R5 program window");
        cmp_range(4 * PB, 3 * PB, "R3 partial program AND");

        // R4 mask cleared after program
        do_load(9, 4, 8'h00);
        do_prog("R5 program window 2");
        do_load(11, 0, 8'hFF);
        do_prog("R5 program window 3");
        cmp_range(9 * PB, 3 * PB, "R4 mask cleared at program end");

        // R4 buffer clear
        for (int i = 0; i < PB; i++) do_load(20, i, 8'h00);
        issue(C_BCLR, '0, 8'h00);
        bm_clear();
        do_prog("R5 program window 4");
        cmp_range(20 * PB, PB, "R4 buffer clear command");

        // R3 most recent load picks page
        do_load(30, 1, 8'h0F);
        do_load(31, 2, 8'hF0);
        do_prog("R5 program window 5");
        cmp_range(30 * PB, 2 * PB, "R3 latest load sets page");

        // R2 byte and page erase directed
        run(C_ERB, AW'(12'h123), 8'h00, OPC, "R5 byte erase window");
        ref_erase(12'h123, 1);
        cmp_range(12'h110, 32, "R2 byte erase");
        run(C_ERP, AW'(12'h2F7), 8'h00, OPC, "R5 page erase window");
        ref_erase(12'h2F0, 16);
        cmp_range(12'h2E0, 48, "R2 page erase");

        // R6 busy command rejected
        issue(C_ERS, AW'(6 * SB + 5), 8'h00);
        repeat (10) @(negedge clk);
        chk(err == 1'b0, "R6 err before reject", err, 0);
        rd_addr = AW'(100);
        #1;
        chk(rd_ok == 1'b0 && rd_data == 8'h00, "R7 read refused while busy", {rd_ok, rd_data}, 0);
        issue(C_ERC, '0, 8'h00);
        chk(err == 1'b1, "R6 err set on busy command", err, 1);
        wait_idle(c);
        ref_erase(6 * SB, SB);
        cmp_range(5 * SB, 3 * SB, "R6 rejected chip erase had no effect");
        issue(C_BCLR, '0, 8'h00);
        chk(err == 1'b0, "R6 err cleared by accepted command", err, 0);

        // R7 security and R8 CRC over secured sector
        sec_mask = 8'h08;
        cmp_range(3 * SB, 32, "R7 secured sector refused");
        cmp_range(2 * SB, 32, "R7 unsecured sector readable");
        run(C_CRC, AW'(3 * SB + 9), 8'h00, SB, "R8 sector crc length");
        chk(crc_out == ref_crc(3 * SB, SB), "R8 crc secured sector", crc_out, ref_crc(3 * SB, SB));
        sec_mask = 8'h00;
        run(C_CRC, '0, 8'h01, TOTAL, "R8 whole crc length");
        chk(crc_out == ref_crc(0, TOTAL), "R8 whole crc", crc_out, ref_crc(0, TOTAL));

        // Random mix of erases and programs
        for (int it = 0; it < 20; it++) begin
            int kind_r, a, pg, n;
            kind_r = int'($urandom % 4);
            a = int'($urandom % TOTAL);
            pg = a / PB;
            if (kind_r == 0) begin
                n = 1 + int'($urandom % PB);
                for (int k = 0; k < n; k++) do_load(pg, int'($urandom % PB), 8'($urandom));
                do_prog("R3 random program window");
                cmp_range((a / SB) * SB, SB, "R3 random program");
            end else if (kind_r == 1) begin
                run(C_ERB, AW'(a), 8'h00, OPC, "R5 random byte erase window");
                ref_erase(a, 1);
                cmp_range((a / SB) * SB, SB, "R2 random byte erase");
            end else if (kind_r == 2) begin
                run(C_ERP, AW'(a), 8'h00, OPC, "R5 random page erase window");
                ref_erase(pg * PB, PB);
                cmp_range((a / SB) * SB, SB, "R2 random page erase");
            end else begin
                run(C_ERS, AW'(a), 8'h00, OPC, "R5 random sector erase window");
                ref_erase((a / SB) * SB, SB);
                cmp_range(0, TOTAL, "R2 random sector erase");
            end
        end
        cmp_range(0, TOTAL, "R3 full array after random mix");
        run(C_CRC, AW'(5 * SB), 8'h00, SB, "R8 sector crc length 2");
        chk(crc_out == ref_crc(5 * SB, SB), "R8 crc after random mix", crc_out, ref_crc(5 * SB, SB));

        // R2 chip erase
        run(C_ERC, '0, 8'h00, OPC, "R5 chip erase window");
        ref_erase(0, TOTAL);
        cmp_range(0, TOTAL, "R2 chip erase all FF");
        run(C_CRC, '0, 8'h01, TOTAL, "R8 whole crc length 2");
        chk(crc_out == ref_crc(0, TOTAL), "R8 crc of erased array", crc_out, ref_crc(0, TOTAL));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule